// File: doc/BRIEF.md
# Wakeup Interrupt Trigger Normalizer

This block sits between a set of raw wakeup interrupt lines and a downstream interrupt controller that accepts only two kinds of request: an active-high level, or a rising-edge pulse. Each pin has its own channel. The channel brings the raw line into the clock domain through a two-flop synchronizer. It then turns active-low levels, falling edges and dual-edge activity into an active-high level or a one-cycle pulse. Finally it gates the result with the pin's enable.

Software controls each pin through a small word-addressed register bus. Every pin has a configuration word that selects its trigger type. The enable for each pin is held in one of two places, depending on the version value fixed for the block. Builds whose version is 0x30200 or higher keep the enable in bit 3 of the pin's own configuration word. Older builds pack the enables 32 to a word in a separate bank. A read-only register reports the version value.

When software changes a pin's trigger type, the old and new interpretations of the input can disagree for a cycle, which could produce a false request. The channel therefore holds its output low in the cycle that follows any write that changes the type.

Top module: `wake_trig_norm`

## Requirements
- R1: After reset every enable and every type field is 0, every `wake_out` bit is low, and every register reads 0 except the version register.
- R2: Type field bits [2:0] of a pin's configuration word select the trigger: 100 = active-high level, 000 = active-low level, 110 = rising edge, 010 = falling edge, 111 = both edges. In active-high level mode, an enabled pin's output equals the raw input as it stood three clock edges earlier. Configuration bits above bit 3 are not stored and read 0.
- R3: In active-low level mode, an enabled pin's output is the inverse of the raw input, with the same three-edge latency.
- R4: In rising-edge mode, a 0-to-1 input change produces a single one-cycle output pulse three edges later. In falling-edge mode, a 1-to-0 change produces the same pulse. No other change produces a pulse.
- R5: In both-edges mode, every input transition produces a one-cycle output pulse three edges later.
- R6: The type codes 001, 011 and 101 never drive the output high.
- R7: A pin whose enable is 0 holds its output low whatever its input and type.
- R8: When the version is 0x30200 or higher, a pin's enable is bit 3 of its configuration word at byte address 0x110 + 4*pin. Reads from the bank region at 0x10 return 0, and writes to it have no effect.
- R9: When the version is below 0x30200, pin p's enable is bit p%32 of the bank word at byte address 0x10 + 4*(p/32). Bank bits beyond the last pin read 0. Bit 3 of a configuration word reads 0, and writing it does not change the enable.
- R10: The register at byte address 0x1000 reads the version parameter and ignores writes. Any other address that maps nothing reads 0.
- R11: A write that changes a pin's type field forces that pin's output low in the cycle after the write, even when the input moved just before the write. A write that leaves the type unchanged does not affect the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 13 | Byte address of the register access |
| bus_wen | input | 1 | Write strobe; the write takes effect at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| raw_in | input | NUM_PINS | Raw, asynchronous interrupt lines |
| wake_out | output | NUM_PINS | Normalized active-high level or rising-pulse requests |

## Verification
The assertions assume that register accesses use word-aligned addresses and that at most one write is presented per clock. They also assume that the raw lines settle before the synchronizer samples them. The bench respects all three: it changes raw lines and bus signals only on the falling clock edge and issues writes one at a time. It also holds each input level for several cycles before reconfiguring a pin, except in the reconfiguration tests, which deliberately place an input change two edges before a type write.

// File: rtl/wtn_pkg.sv
package wtn_pkg;

    localparam int ADDR_W = 13;

    localparam logic [31:0]       PER_PIN_EN_VERSION = 32'h0003_0200;
    localparam logic [ADDR_W-1:0] BANK_BASE          = 13'h0010;
    localparam logic [ADDR_W-1:0] CFG_BASE           = 13'h0110;
    localparam logic [ADDR_W-1:0] VER_ADDR           = 13'h1000;

    localparam logic [2:0] TRIG_LVL_LO = 3'b000;
    localparam logic [2:0] TRIG_FALL   = 3'b010;
    localparam logic [2:0] TRIG_LVL_HI = 3'b100;
    localparam logic [2:0] TRIG_RISE   = 3'b110;
    localparam logic [2:0] TRIG_BOTH   = 3'b111;

    typedef struct packed {
        logic       en;
        logic [2:0] trig;
    } pin_cfg_t;

    // Normalized request for one pin given current and previous synced samples
    function automatic logic trig_event(logic [2:0] trig, logic cur, logic prev);
        case (trig)
            TRIG_LVL_LO: return !cur;
            TRIG_FALL:   return prev & !cur;
            TRIG_LVL_HI: return cur;
            TRIG_RISE:   return cur & !prev;
            TRIG_BOTH:   return cur ^ prev;
            default:     return 1'b0;
        endcase
    endfunction

    function automatic logic is_single_edge(logic [2:0] trig);
        return (trig == TRIG_RISE) || (trig == TRIG_FALL);
    endfunction

    function automatic logic is_undefined(logic [2:0] trig);
        return (trig == 3'b001) || (trig == 3'b011) || (trig == 3'b101);
    endfunction

endpackage

// File: rtl/wtn_sync.sv
module wtn_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= din;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/wtn_chan.sv
module wtn_chan
    import wtn_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sync_i,
    input  pin_cfg_t cfg_i,
    input  logic     chg_i,
    output logic     wake_o
);

    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            wake_o <= 1'b0;
        end else begin
            prev_q <= sync_i;
            // A type change hides whatever the old/new decode would produce this cycle
            wake_o <= chg_i ? 1'b0 : (cfg_i.en & trig_event(cfg_i.trig, sync_i, prev_q));
        end
    end

    assert_quiet_disabled_R7: assert property (@(posedge clk) disable iff (rst)
        !cfg_i.en |=> !wake_o);

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        (wake_o && is_single_edge(cfg_i.trig)) |=> !wake_o);

    assert_undefined_silent_R6: assert property (@(posedge clk) disable iff (rst)
        is_undefined(cfg_i.trig) |=> !wake_o);

    assert_reconfig_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        chg_i |=> !wake_o);

endmodule

// File: rtl/wtn_regs.sv
module wtn_regs
    import wtn_pkg::*;
#(
    parameter int          NUM_PINS = 8,
    parameter logic [31:0] VERSION  = 32'h0003_0200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output pin_cfg_t          cfg_o [NUM_PINS],
    output logic [NUM_PINS-1:0] chg_o
);

    localparam bit PER_PIN_EN = (VERSION >= PER_PIN_EN_VERSION);
    localparam int BANK_WORDS = (NUM_PINS + 31) / 32;
    localparam logic [ADDR_W-1:0] CFG_LIMIT  = CFG_BASE + ADDR_W'(4 * NUM_PINS);
    localparam logic [ADDR_W-1:0] BANK_LIMIT = BANK_BASE + ADDR_W'(4 * BANK_WORDS);

    logic [2:0]          trig_q [NUM_PINS];
    logic [NUM_PINS-1:0] en_q;

    logic              aligned, cfg_hit, bank_range, bank_hit;
    logic [ADDR_W-3:0] cfg_idx, bank_idx;

    always_comb begin
        aligned    = (bus_addr[1:0] == 2'b00);
        cfg_hit    = aligned && (bus_addr >= CFG_BASE) && (bus_addr < CFG_LIMIT);
        bank_range = aligned && (bus_addr >= BANK_BASE) && (bus_addr < BANK_LIMIT);
        bank_hit   = bank_range && !PER_PIN_EN;
        cfg_idx    = bus_addr[ADDR_W-1:2] - CFG_BASE[ADDR_W-1:2];
        bank_idx   = bus_addr[ADDR_W-1:2] - BANK_BASE[ADDR_W-1:2];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NUM_PINS; p++) trig_q[p] <= '0;
            en_q <= '0;
        end else if (bus_wen) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (cfg_hit && cfg_idx == (ADDR_W-2)'(p)) begin
                    trig_q[p] <= bus_wdata[2:0];
                    if (PER_PIN_EN) en_q[p] <= bus_wdata[3];
                end
                if (bank_hit && bank_idx == (ADDR_W-2)'(p / 32))
                    en_q[p] <= bus_wdata[p % 32];
            end
        end
    end

    always_comb begin
        for (int p = 0; p < NUM_PINS; p++) begin
            cfg_o[p] = '{en: en_q[p], trig: trig_q[p]};
            chg_o[p] = bus_wen && cfg_hit && (cfg_idx == (ADDR_W-2)'(p))
                       && (bus_wdata[2:0] != trig_q[p]);
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == VER_ADDR) begin
            bus_rdata = VERSION;
        end else if (cfg_hit) begin
            for (int p = 0; p < NUM_PINS; p++)
                if (cfg_idx == (ADDR_W-2)'(p))
                    bus_rdata = {28'b0, PER_PIN_EN & en_q[p], trig_q[p]};
        end else if (bank_hit) begin
            for (int p = 0; p < NUM_PINS; p++)
                if (bank_idx == (ADDR_W-2)'(p / 32))
                    bus_rdata[p % 32] = en_q[p];
        end
    end

    assert_version_read_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == VER_ADDR) |-> (bus_rdata == VERSION));

    generate
        if (PER_PIN_EN) begin : g_per_pin
            assert_bank_ignored_R8: assert property (@(posedge clk) disable iff (rst)
                (bus_wen && bank_range) |=> $stable(en_q));
        end else begin : g_packed
            assert_cfg_no_enable_R9: assert property (@(posedge clk) disable iff (rst)
                (bus_wen && cfg_hit) |=> $stable(en_q));
        end
    endgenerate

endmodule

// File: rtl/wake_trig_norm.sv
module wake_trig_norm
    import wtn_pkg::*;
#(
    parameter int          NUM_PINS = 8,
    parameter logic [31:0] VERSION  = 32'h0003_0200
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [12:0]         bus_addr,
    input  logic                bus_wen,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] raw_in,
    output logic [NUM_PINS-1:0] wake_out
);

    localparam int SYNC_STAGES = 2;

    initial begin
        assert (NUM_PINS >= 1 && NUM_PINS <= 256)
            else $error("NUM_PINS must lie in 1..256");
    end

    pin_cfg_t            cfg   [NUM_PINS];
    logic [NUM_PINS-1:0] chg;
    logic [NUM_PINS-1:0] synced;

    wtn_regs #(.NUM_PINS(NUM_PINS), .VERSION(VERSION)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wen   (bus_wen),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cfg_o     (cfg),
        .chg_o     (chg)
    );

    wtn_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_in),
        .dout (synced)
    );

    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_chan
            wtn_chan u_chan (
                .clk    (clk),
                .rst    (rst),
                .sync_i (synced[p]),
                .cfg_i  (cfg[p]),
                .chg_i  (chg[p]),
                .wake_o (wake_out[p])
            );
        end
    endgenerate

endmodule

// File: tb/wake_trig_norm_bench.sv
module wake_trig_norm_bench;

    localparam int NP_N = 8;
    localparam int NP_O = 40;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [12:0]     addr = '0;
    logic [31:0]     wdata = '0;
    logic            wen_n = 1'b0, wen_o = 1'b0;
    logic [31:0]     rdata_n, rdata_o;
    logic [NP_N-1:0] raw_n = '0, out_n;
    logic [NP_O-1:0] raw_o = '0, out_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    wake_trig_norm #(.NUM_PINS(NP_N), .VERSION(32'h0003_0200)) u_wake_trig_norm (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wen(wen_n), .bus_wdata(wdata),
        .bus_rdata(rdata_n), .raw_in(raw_n), .wake_out(out_n));

    wake_trig_norm #(.NUM_PINS(NP_O), .VERSION(32'h0003_0100)) u_wake_trig_norm_legacy (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wen(wen_o), .bus_wdata(wdata),
        .bus_rdata(rdata_o), .raw_in(raw_o), .wake_out(out_o));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge
    task automatic wr_n(input logic [12:0] a, input logic [31:0] d);
        addr = a; wdata = d; wen_n = 1'b1;
        @(posedge clk); @(negedge clk);
        wen_n = 1'b0;
    endtask

    task automatic wr_o(input logic [12:0] a, input logic [31:0] d);
        addr = a; wdata = d; wen_o = 1'b1;
        @(posedge clk); @(negedge clk);
        wen_o = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic to_output;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic bit lvl_of(int m, bit v);
        if (m == 0) return !v;
        if (m == 4) return v;
        return 1'b0;
    endfunction

    function automatic bit first_of(int m, bit pv, bit cv);
        case (m)
            0, 4:    return lvl_of(m, cv);
            6:       return cv & !pv;
            2:       return pv & !cv;
            7:       return cv ^ pv;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string tag_of(int m);
        case (m)
            4:       return "R2 level-high";
            0:       return "R3 level-low";
            6, 2:    return "R4 single-edge";
            7:       return "R5 both-edges";
            default: return "R6 undefined code";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        settle(1);

        // R1: reset state
        chk("R1 outputs low new", 64'(out_n), 64'h0);
        chk("R1 outputs low legacy", 64'(out_o), 64'h0);
        addr = 13'h110 + 13'd4 * 13'd5; #1;
        chk("R1 cfg reads 0", 64'(rdata_n), 64'h0);
        addr = 13'h010; #1;
        chk("R1 bank reads 0", 64'(rdata_o), 64'h0);
        @(negedge clk);

        // Sweep every pin and every type code on the per-pin enable build
        for (int p = 0; p < NP_N; p++) begin
            for (int m = 0; m < 8; m++) begin
                logic [12:0] ca;
                ca = 13'h110 + 13'(4 * p);
                raw_n = '0;
                wr_n(ca, 32'(8 | m));
                settle(4);
                chk({tag_of(m), " idle"}, 64'(out_n), 64'(lvl_of(m, 1'b0)) << p);
                raw_n[p] = 1'b1;
                to_output;
                chk({tag_of(m), " on rise"}, 64'(out_n), 64'(first_of(m, 1'b0, 1'b1)) << p);
                @(negedge clk);
                chk({tag_of(m), " after rise"}, 64'(out_n), 64'(lvl_of(m, 1'b1)) << p);
                raw_n[p] = 1'b0;
                to_output;
                chk({tag_of(m), " on fall"}, 64'(out_n), 64'(first_of(m, 1'b1, 1'b0)) << p);
                @(negedge clk);
                chk({tag_of(m), " after fall"}, 64'(out_n), 64'(lvl_of(m, 1'b0)) << p);
                wr_n(ca, 32'h0);
                settle(2);
            end
        end

        // R7: type set but enable clear
        raw_n[2] = 1'b1;
        wr_n(13'h118, 32'h4);
        settle(4);
        chk("R7 disabled pin stays low", 64'(out_n), 64'h0);
        addr = 13'h118; #1;
        chk("R7 cfg readback", 64'(rdata_n), 64'h4);
        @(negedge clk);

        // R8: bank writes ignored on the per-pin build
        raw_n = '0;
        wr_n(13'h118, 32'h0);
        wr_n(13'h010, 32'hFFFF_FFFF);
        settle(4);
        chk("R8 bank write no enable", 64'(out_n), 64'h0);
        addr = 13'h010; #1;
        chk("R8 bank reads 0", 64'(rdata_n), 64'h0);
        @(negedge clk);

        // R2: upper config bits not stored
        wr_n(13'h11C, 32'hFFFF_FF5C);
        addr = 13'h11C; #1;
        chk("R2 only bits 3:0 kept", 64'(rdata_n), 64'hC);
        @(negedge clk);
        wr_n(13'h11C, 32'h0);

        // R10: version register
        wr_n(13'h1000, 32'h0);
        addr = 13'h1000; #1;
        chk("R10 version new", 64'(rdata_n), 64'h30200);
        addr = 13'h0800; #1;
        chk("R10 unmapped reads 0", 64'(rdata_n), 64'h0);
        @(negedge clk);

        // R11: input edge right before a type-changing write is swallowed
        wr_n(13'h114, 32'hE);
        settle(4);
        raw_n[1] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        wr_n(13'h114, 32'hF);
        chk("R11 suppressed after type change", 64'(out_n), 64'h0);
        @(negedge clk);
        chk("R11 still quiet", 64'(out_n), 64'h0);
        // Same-type write does not suppress
        settle(3);
        raw_n[1] = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        wr_n(13'h114, 32'hF);
        chk("R11 same-type write keeps event", 64'(out_n), 64'h2);
        wr_n(13'h114, 32'h0);
        settle(3);

        // R9: packed enable bank on the legacy build
        addr = 13'h1000; #1;
        chk("R10 version legacy", 64'(rdata_o), 64'h30100);
        @(negedge clk);
        wr_o(13'h19C, 32'hE);
        addr = 13'h19C; #1;
        chk("R9 cfg bit3 reads 0", 64'(rdata_o), 64'h6);
        @(negedge clk);
        raw_o[35] = 1'b1;
        settle(4);
        chk("R9 cfg bit3 gives no enable", 64'(out_o), 64'h0);
        raw_o[35] = 1'b0;
        wr_o(13'h014, 32'h8);
        addr = 13'h014; #1;
        chk("R9 bank word1 readback", 64'(rdata_o), 64'h8);
        @(negedge clk);
        settle(3);
        raw_o[35] = 1'b1;
        to_output;
        chk("R9 pin35 rising pulse", 64'(out_o), 64'h1 << 35);
        @(negedge clk);
        chk("R9 pin35 pulse ends", 64'(out_o), 64'h0);
        wr_o(13'h110, 32'h4);
        wr_o(13'h010, 32'h1);
        raw_o[0] = 1'b1;
        settle(4);
        chk("R9 pin0 level via bank word0", 64'(out_o), 64'h1);
        wr_o(13'h014, 32'hFFFF_FFFF);
        addr = 13'h014; #1;
        chk("R9 bits past last pin read 0", 64'(rdata_o), 64'hFF);
        @(negedge clk);
        settle(3);
        chk("R3 active-low pins with low input", 64'(out_o), (64'hF7 << 32) | 64'h1);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule